// File: doc/BRIEF.md
# Half-Bridge Dead-Time Sequencer

This block runs one phase of a half-bridge from two independent PWM requests, one for the high-side switch and one for the low-side switch. It produces the two gate enables. It adds a blanking gap only when one side hands over to the other while the departing gate may still be charged.

Each gate has a comparator input that reports when its gate voltage has dropped below the off threshold. When a side's request is removed, the sequencer opens a turn-off window whose length is the programmable drive-timeout count. If the other side is requested while that window is open, the new gate waits until the departing gate reports off, and then waits a further programmable dead-time count. If the departing gate still has not reported off when the window closes, the block raises a sticky fault and holds both gates off.

All inputs are level signals. There is no data stream, so no valid/ready handshake is involved and back-pressure does not apply. The command and comparator inputs are treated as asynchronous. The fault-clear input is expected to be synchronous to `clk`.

Top module: `hb_deadtime_seq`

## Requirements
- R1: The two request inputs and the two comparator inputs pass through two flip-flop stages. From the idle state, a request of {high,low} = 01 or 10 applied before a rising edge turns on the requested gate after the third rising edge, and not after the second.
- R2: A change from request 11 with both gates off to 10 or 01 turns on the requested side with the same three-edge latency and no added dead time.
- R3: The two gate enables are never high in the same cycle. Request 11 keeps the side that is already on, or keeps both off if neither is on.
- R4: Removing the request of the side that is on opens a turn-off window that lasts the latched drive-timeout count plus one cycle. During this window both gates are off.
- R5: If the opposite side is requested while the window is open, the new gate stays off until the synchronised off flag of the departing gate is seen. The off flag is ignored during the first three cycles of the window. The new gate then waits the dead-time count plus one cycle. The number of cycles with both gates low is therefore at least the discharge time plus the dead-time count, and at most that sum plus six.
- R6: If the opposite side is requested only after the window has closed with the departing gate off, the new gate turns on with the three-edge latency of R1.
- R7: If the window closes while the departing gate's synchronised off flag is still low, `fault` goes high and both gates are forced low.
- R8: `fault` stays high until `fault_clr` is high on a rising edge at which both synchronised requests are 0. A clear pulse given while any request is high has no effect.
- R9: The dead-time and drive-timeout counts are captured only while the sequencer is idle. A change made while a gate is on does not affect the handover that follows.
- R10: If the departing side is requested again while its window is open, and the other side is not requested, that side turns back on without a fault and without waiting for the window to close.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_hi | input | 1 | High-side PWM request (asynchronous) |
| cmd_lo | input | 1 | Low-side PWM request (asynchronous) |
| hi_gate_off | input | 1 | High-side gate voltage below the off threshold (asynchronous) |
| lo_gate_off | input | 1 | Low-side gate voltage below the off threshold (asynchronous) |
| dead_cnt | input | CNT_W | Fixed dead-time count, in cycles |
| drive_to | input | CNT_W | Turn-off window length, in cycles |
| fault_clr | input | 1 | Fault clear, synchronous to clk |
| gate_hi | output | 1 | High-side gate enable |
| gate_lo | output | 1 | Low-side gate enable |
| fault | output | 1 | Sticky gate-drive fault |

## Verification
The fault-hold property assumes that `fault_clr` is a synchronous level, sampled on the same edges as the state. The bench therefore changes it, and every other input, only on falling clock edges.

The gap and exclusivity properties make no assumption about the inputs. The bench's gate model keeps the comparator flags physically plausible: a flag drops the cycle after its enable rises, and it returns only after a programmable discharge time with the enable low.

In the random phase, the discharge times are kept well inside the drive window, so no fault is expected there. Faults are provoked only by a directed case that makes the discharge time much longer than the window.

// File: rtl/hb_pkg.sv
package hb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ON    = 3'd1,
    ST_TOFF  = 3'd2,
    ST_DEAD  = 3'd3,
    ST_FAULT = 3'd4
  } hb_state_e;
endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg[0] <= '0;
        else        stg[0] <= d;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg[i] <= '0;
        else        stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/hb_timer.sv
module hb_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)            cnt_q <= '0;
    else if (load)         cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/hb_ctrl.sv
module hb_ctrl
  import hb_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int BLANK = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             c_hi,
  input  logic             c_lo,
  input  logic             off_hi,
  input  logic             off_lo,
  input  logic             fault_clr,
  input  logic [CNT_W-1:0] dead_cnt,
  input  logic [CNT_W-1:0] drive_to,
  input  logic             win_zero,
  input  logic             dead_zero,
  output logic             win_load,
  output logic [CNT_W-1:0] win_val,
  output logic             dead_load,
  output logic [CNT_W-1:0] dead_val,
  output logic             gate_hi,
  output logic             gate_lo,
  output logic             fault
);
  localparam int BW = $clog2(BLANK + 1);

  hb_state_e        st_q, st_d;
  logic             side_q, side_d;   // 1: high side owns the phase
  logic [CNT_W-1:0] dt_q, to_q;
  logic [BW-1:0]    blank_q;
  logic             blank_load;

  logic own, opp, dep_off, blank_done;
  assign own        = side_q ? c_hi : c_lo;
  assign opp        = side_q ? c_lo : c_hi;
  assign dep_off    = side_q ? off_hi : off_lo;
  assign blank_done = (blank_q == '0);

  always_comb begin
    st_d       = st_q;
    side_d     = side_q;
    win_load   = 1'b0;
    dead_load  = 1'b0;
    blank_load = 1'b0;
    case (st_q)
      ST_IDLE:
        if (c_hi ^ c_lo) begin
          st_d   = ST_ON;
          side_d = c_hi;
        end
      ST_ON:
        if (!own) begin
          st_d       = ST_TOFF;
          win_load   = 1'b1;
          blank_load = 1'b1;
        end
      ST_TOFF:
        if (dep_off && blank_done && opp && !own) begin
          st_d      = ST_DEAD;
          dead_load = 1'b1;
          side_d    = ~side_q;
        end else if (own && !opp) begin
          st_d = ST_ON;
        end else if (win_zero) begin
          st_d = dep_off ? ST_IDLE : ST_FAULT;
        end
      ST_DEAD:
        if (dead_zero) st_d = own ? ST_ON : ST_IDLE;
      ST_FAULT:
        if (fault_clr && !c_hi && !c_lo) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      side_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      side_q <= side_d;
    end

  // counts are sampled only while idle
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      dt_q <= '0;
      to_q <= '0;
    end else if (st_q == ST_IDLE) begin
      dt_q <= dead_cnt;
      to_q <= drive_to;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)               blank_q <= '0;
    else if (blank_load)      blank_q <= BW'(BLANK);
    else if (!blank_done)     blank_q <= blank_q - 1'b1;

  assign win_val  = to_q;
  assign dead_val = dt_q;
  assign gate_hi  = (st_q == ST_ON) && side_q;
  assign gate_lo  = (st_q == ST_ON) && !side_q;
  assign fault    = (st_q == ST_FAULT);
endmodule

// File: rtl/hb_deadtime_seq.sv
module hb_deadtime_seq #(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_hi,
  input  logic             cmd_lo,
  input  logic             hi_gate_off,
  input  logic             lo_gate_off,
  input  logic [CNT_W-1:0] dead_cnt,
  input  logic [CNT_W-1:0] drive_to,
  input  logic             fault_clr,
  output logic             gate_hi,
  output logic             gate_lo,
  output logic             fault
);
  localparam int BLANK = SYNC_STAGES + 1;

  logic [3:0]       s_q;
  logic             win_load, dead_load, win_zero, dead_zero;
  logic [CNT_W-1:0] win_val, dead_val;

  hb_sync #(.W(4), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({cmd_hi, cmd_lo, hi_gate_off, lo_gate_off}),
    .q    (s_q)
  );

  hb_timer #(.CNT_W(CNT_W)) u_win_tmr (
    .clk(clk), .rst_n(rst_n), .load(win_load), .load_val(win_val), .zero(win_zero)
  );

  hb_timer #(.CNT_W(CNT_W)) u_dead_tmr (
    .clk(clk), .rst_n(rst_n), .load(dead_load), .load_val(dead_val), .zero(dead_zero)
  );

  hb_ctrl #(.CNT_W(CNT_W), .BLANK(BLANK)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .c_hi     (s_q[3]),
    .c_lo     (s_q[2]),
    .off_hi   (s_q[1]),
    .off_lo   (s_q[0]),
    .fault_clr(fault_clr),
    .dead_cnt (dead_cnt),
    .drive_to (drive_to),
    .win_zero (win_zero),
    .dead_zero(dead_zero),
    .win_load (win_load),
    .win_val  (win_val),
    .dead_load(dead_load),
    .dead_val (dead_val),
    .gate_hi  (gate_hi),
    .gate_lo  (gate_lo),
    .fault    (fault)
  );
endmodule

// File: rtl/hb_deadtime_seq_chk.sv
module hb_deadtime_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic gate_hi,
  input logic gate_lo,
  input logic fault,
  input logic fault_clr
);
  // R3
  gates_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_hi && gate_lo));

  // R7
  fault_blocks_gates_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (!gate_hi && !gate_lo));

  // R8
  fault_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && !fault_clr) |=> fault);

  // R5
  hi_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_hi) |-> !$past(gate_lo));

  // R5
  lo_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_lo) |-> !$past(gate_hi));
endmodule

bind hb_deadtime_seq hb_deadtime_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .gate_hi(gate_hi), .gate_lo(gate_lo),
  .fault(fault), .fault_clr(fault_clr)
);

// File: tb/tb_hb_deadtime_seq.sv
`timescale 1ns/1ps
module tb_hb_deadtime_seq;
  localparam int CNT_W = 8;
  localparam int T_WIN = 40;
  localparam int D_DEF = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_hi = 1'b0, cmd_lo = 1'b0, fault_clr = 1'b0;
  logic [CNT_W-1:0] dead_cnt = CNT_W'(D_DEF);
  logic [CNT_W-1:0] drive_to = CNT_W'(T_WIN);
  logic hi_gate_off, lo_gate_off, gate_hi, gate_lo, fault;

  int total = 0, bad = 0, overlaps = 0;
  int disch_hi = 6, disch_lo = 6;
  int hcnt = 1000, lcnt = 1000;
  bit done = 0;

  always #2 clk = ~clk;

  hb_deadtime_seq #(.CNT_W(CNT_W), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_hi(cmd_hi), .cmd_lo(cmd_lo),
    .hi_gate_off(hi_gate_off), .lo_gate_off(lo_gate_off),
    .dead_cnt(dead_cnt), .drive_to(drive_to), .fault_clr(fault_clr),
    .gate_hi(gate_hi), .gate_lo(gate_lo), .fault(fault)
  );

  // gate discharge model
  always @(posedge clk) begin
    if (gate_hi) hcnt <= 0; else if (hcnt < 1000) hcnt <= hcnt + 1;
    if (gate_lo) lcnt <= 0; else if (lcnt < 1000) lcnt <= lcnt + 1;
  end
  assign hi_gate_off = (hcnt >= disch_hi);
  assign lo_gate_off = (lcnt >= disch_lo);

  always @(negedge clk) if (rst_n && gate_hi && gate_lo) overlaps++;

  function automatic int gap_min(int disch, int d); return disch + d; endfunction
  function automatic int gap_max(int disch, int d); return disch + d + 6; endfunction
  function automatic int settled_hi(logic [1:0] c); return (c == 2'b10) ? 1 : 0; endfunction
  function automatic int settled_lo(logic [1:0] c); return (c == 2'b01) ? 1 : 0; endfunction

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_rng(input string req, input int act, input int lo, input int hi);
    total++;
    if (act < lo || act > hi) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic set_cmd(input logic [1:0] c);
    @(negedge clk);
    cmd_hi = c[1];
    cmd_lo = c[0];
  endtask

  task automatic idle_wait(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // apply c, count cycles with both gates low until the wanted gate rises
  task automatic handover(input logic [1:0] c, output int gap);
    gap = 0;
    set_cmd(c);
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if ((c[1] && gate_hi) || (c[0] && gate_lo)) break;
      if (!gate_hi && !gate_lo) gap++;
    end
  endtask

  // latency: off after two edges, on after the third
  task automatic latency(input string req, input logic [1:0] c);
    set_cmd(c);
    @(posedge clk); @(posedge clk); #1;
    check({req, " not yet on"}, int'(c[1] ? gate_hi : gate_lo), 0);
    @(posedge clk); #1;
    check({req, " on at third edge"}, int'(c[1] ? gate_hi : gate_lo), 1);
  endtask

  initial begin
    #(4 * 190000);
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int g;
    void'($urandom(32'd4242));
    idle_wait(3);
    check("R3 reset gate_hi", int'(gate_hi), 0);
    check("R3 reset gate_lo", int'(gate_lo), 0);
    check("R7 reset fault", int'(fault), 0);
    @(negedge clk); rst_n = 1'b1;
    idle_wait(4);

    // R1 direct enable from idle
    latency("R1 01 from idle", 2'b01);
    idle_wait(10);

    // R5 handover low -> high with dead time
    handover(2'b10, g);
    check_rng("R5 gap lo->hi", g, gap_min(disch_lo, D_DEF), gap_max(disch_lo, D_DEF));
    check("R5 hi on after handover", int'(gate_hi), 1);

    // R9 count change while on is not used
    @(negedge clk); dead_cnt = 8'd60;
    idle_wait(5);
    handover(2'b01, g);
    check_rng("R9 old dead count kept", g, gap_min(disch_hi, D_DEF), gap_max(disch_hi, D_DEF));

    // R9 new count is taken in idle
    set_cmd(2'b00);
    idle_wait(80);
    latency("R6 direct after idle", 2'b10);
    idle_wait(10);
    handover(2'b01, g);
    check_rng("R9 new dead count used", g, gap_min(disch_hi, 60), gap_max(disch_hi, 60));
    @(negedge clk); dead_cnt = CNT_W'(D_DEF);

    // R4/R6 opposite request after the window closed
    set_cmd(2'b00);
    idle_wait(T_WIN + 20);
    check("R4 no fault after clean window", int'(fault), 0);
    latency("R6 enable after window", 2'b10);
    idle_wait(10);

    // R10 same side requested again inside the window
    set_cmd(2'b00);
    idle_wait(2);
    set_cmd(2'b10);
    idle_wait(12);
    check("R10 hi back on", int'(gate_hi), 1);
    check("R10 no fault", int'(fault), 0);

    // R2 11 with nothing on, then 10
    set_cmd(2'b00);
    idle_wait(T_WIN + 20);
    set_cmd(2'b11);
    idle_wait(10);
    check("R3 11 from idle keeps hi off", int'(gate_hi), 0);
    check("R3 11 from idle keeps lo off", int'(gate_lo), 0);
    latency("R2 11 to 10", 2'b10);

    // R3 11 while high on
    set_cmd(2'b11);
    idle_wait(20);
    check("R3 11 keeps hi", int'(gate_hi), 1);
    check("R3 11 keeps lo off", int'(gate_lo), 0);

    // R7 slow discharge -> fault
    disch_hi = T_WIN + 30;
    set_cmd(2'b00);
    idle_wait(T_WIN + 10);
    check("R7 fault raised", int'(fault), 1);
    set_cmd(2'b01);
    idle_wait(10);
    check("R7 lo forced off", int'(gate_lo), 0);

    // R8 clear ignored while a request is high
    @(negedge clk); fault_clr = 1'b1;
    @(negedge clk); fault_clr = 1'b0;
    idle_wait(2);
    check("R8 clear ignored with request", int'(fault), 1);
    set_cmd(2'b00);
    idle_wait(5);
    @(negedge clk); fault_clr = 1'b1;
    @(negedge clk); fault_clr = 1'b0;
    check("R8 clear accepted", int'(fault), 0);
    disch_hi = 6;
    idle_wait(80);

    // random phase
    for (int it = 0; it < 150; it++) begin
      logic [1:0] sc;
      disch_hi = 1 + int'($urandom % 20);
      disch_lo = 1 + int'($urandom % 20);
      set_cmd(2'($urandom));
      idle_wait(1 + int'($urandom % 15));
      sc = 2'($urandom);
      set_cmd(sc);
      idle_wait(100);
      if (sc != 2'b11) begin
        check("R5 random settled hi", int'(gate_hi), settled_hi(sc));
        check("R5 random settled lo", int'(gate_lo), settled_lo(sc));
      end
      check("R7 random no fault", int'(fault), 0);
    end

    check("R3 no overlap seen", overlaps, 0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule